// File: doc/BRIEF.md
# I2C Client Address Matcher

This block decides whether the address phase of an I2C transfer is aimed at this client. A bit-level receiver, which lies outside the block, hands over each received byte on a valid/ready stream. A flag marks the first byte after a START or a repeated START, and a separate pulse reports a STOP. The block compares the address carried in those bytes with a configured own address and with a second configured value. According to a 2-bit mode, the second value acts as a don't-care mask, as an alternate address, or as the lower bound of an address range. Both 7-bit addressing and 10-bit addressing (a header byte followed by a low byte) are supported, and recognition of the all-zero general-call byte can be enabled.

On a match the block raises a single-cycle pulse. In the same clock it updates a latched read/write direction and a latched general-call indication. Bytes that do not match leave both latched outputs as they were. The stream never applies back-pressure: `in_ready` is tied high, so each cycle with `in_valid` high consumes one byte, and the receiver may present a new byte in every cycle. The configuration inputs are expected to come from registers that reset to zero, which leaves 10-bit mode and general call disabled after reset.

Top module: `i2c_addr_match`

## Requirements
- R1: While and after reset, `match_pulse`, `rd_dir` and `gen_call` are 0, and no 10-bit write match is held.
- R2: In 7-bit mode (`cfg_ten_en`=0), a first byte (`in_first`=1) with bits [7:1] equal to `cfg_addr[6:0]` produces a match: `match_pulse` goes high for exactly one clock, on the cycle after the byte's strobe, and `rd_dir` takes byte bit 0 (1 means read). Only bits [6:0] of `cfg_addr` and `cfg_second` take part.
- R3: When `cfg_mode` is 0 or 3 (mask), an address bit whose `cfg_second` bit is 1 is don't-care, and every other bit must equal `cfg_addr`.
- R4: When `cfg_mode` is 1 (dual), the address matches if it equals either `cfg_addr` or `cfg_second`.
- R5: When `cfg_mode` is 2 (range), the address matches when `cfg_second` <= address <= `cfg_addr`, with both bounds included.
- R6: A first byte of 0x00 with `cfg_gc_en`=1 is a general call: it matches in either addressing mode, sets `rd_dir`=0 and sets `gen_call`=1. With `cfg_gc_en`=0, a 0x00 first byte never matches.
- R7: In 10-bit mode a write starts with the header byte 11110, then address bits [9:8], then 0 (bit 0). The match is decided only on the next non-first byte, which carries address bits [7:0]; all ten bits take part in the compare. A header byte alone raises no pulse.
- R8: In 10-bit mode a first byte 11110, then bits [9:8], then 1 (bit 0) matches as a read (`rd_dir`=1) only while a 10-bit write match is held with the same bits [9:8]. The hold is set by a 10-bit write match. It is cleared by a STOP and by a new 10-bit write header.
- R9: A byte that does not match raises no pulse and leaves `rd_dir` and `gen_call` unchanged.
- R10: A byte strobe in the same cycle as `bus_stop` is discarded: no pulse results, and the 10-bit hold and any pending header are cleared.
- R11: `in_ready` is always 1. A non-first byte is ignored unless it is the low byte awaited after a 10-bit write header.
- R12: `gen_call` is rewritten on every match: 1 for a general call, 0 for any other match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte valid |
| in_ready | output | 1 | Always 1; a byte is accepted whenever valid is high |
| in_data | input | 8 | Received byte, MSB first as on the bus |
| in_first | input | 1 | Byte is the first after a START or repeated START |
| bus_stop | input | 1 | One-cycle STOP indication |
| cfg_addr | input | 10 | Own address; upper bound in range mode |
| cfg_second | input | 10 | Mask, alternate address or lower bound |
| cfg_mode | input | 2 | 0/3 mask, 1 dual, 2 range |
| cfg_ten_en | input | 1 | 1 selects 10-bit addressing |
| cfg_gc_en | input | 1 | 1 enables general-call recognition |
| match_pulse | output | 1 | One-cycle match indication |
| rd_dir | output | 1 | Direction of the last match, 1 = read |
| gen_call | output | 1 | Last match was a general call |

## Verification
A STOP and a byte strobe can land in the same clock. In that cycle the STOP must win: the byte is dropped, and both the 10-bit hold and any pending header are cleared. The bench provokes this with STOP pulses placed on strobe cycles at random, and also directly between a 10-bit write match and the read header that follows it. It judges the result by the missing pulse on that byte and by the failed read re-match afterwards, both compared with its own reference model.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int AM_AW = 10;
  localparam int AM_NW = 7;
  localparam int AM_DW = 8;

  typedef enum logic [1:0] {
    AM_MASK  = 2'd0,
    AM_DUAL  = 2'd1,
    AM_RANGE = 2'd2,
    AM_RSVD  = 2'd3
  } am_mode_e;

  typedef struct packed {
    logic take;
    logic dir;
    logic gc;
  } am_event_t;
endpackage

// File: rtl/am_cmp.sv
module am_cmp
  import i2c_am_pkg::*;
#(
  parameter int AW = AM_AW,
  parameter int NW = AM_NW,
  parameter bit WIDE = 1'b0
) (
  input  logic [1:0]    mode,
  input  logic [AW-1:0] cand,
  input  logic [AW-1:0] own,
  input  logic [AW-1:0] second,
  output logic          hit
);
  localparam logic [AW-1:0] NARROW_M = AW'((1 << NW) - 1);
  localparam logic [AW-1:0] WM = WIDE ? {AW{1'b1}} : NARROW_M;

  logic [AW-1:0] a, p, s;
  assign a = cand & WM;
  assign p = own & WM;
  assign s = second & WM;

  always_comb begin
    unique case (am_mode_e'(mode))
      AM_DUAL:  hit = (a == p) || (a == s);
      AM_RANGE: hit = (a >= s) && (a <= p);
      default:  hit = (((a ^ p) & ~s) == '0);
    endcase
  end
endmodule

// File: rtl/am_phase.sv
module am_phase
  import i2c_am_pkg::*;
#(
  parameter int AW = AM_AW,
  parameter int DW = AM_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_ev,
  input  logic          stop,
  input  logic          first,
  input  logic [DW-1:0] data,
  input  logic          ten_en,
  input  logic          gc_en,
  input  logic          hit7,
  input  logic          hit10,
  output logic [AW-1:0] cand7,
  output logic [AW-1:0] cand10,
  output am_event_t     ev
);
  localparam int HW = AW - DW;

  logic          wait_q, held_q;
  logic [HW-1:0] hi_q, held_hi_q;
  logic          hdr, gcall, wr_hdr;

  assign hdr    = (data[7:3] == 5'b11110);
  assign gcall  = gc_en && (data == '0);
  assign wr_hdr = ten_en && hdr && !data[0];
  assign cand7  = AW'(data[DW-1:1]);
  assign cand10 = {hi_q, data};

  always_comb begin
    ev = '0;
    if (byte_ev) begin
      if (first) begin
        if (gcall) begin
          ev.take = 1'b1;
          ev.gc   = 1'b1;
        end else if (!ten_en) begin
          ev.take = hit7 && (data != '0);
          ev.dir  = data[0];
        end else if (hdr && data[0]) begin
          ev.take = held_q && (held_hi_q == data[HW:1]);
          ev.dir  = 1'b1;
        end
      end else if (wait_q) begin
        ev.take = hit10;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q    <= 1'b0;
      held_q    <= 1'b0;
      hi_q      <= '0;
      held_hi_q <= '0;
    end else if (stop) begin
      wait_q <= 1'b0;
      held_q <= 1'b0;
    end else if (byte_ev) begin
      if (first) begin
        wait_q <= wr_hdr;
        if (wr_hdr) begin
          hi_q   <= data[HW:1];
          held_q <= 1'b0;
        end
      end else begin
        wait_q <= 1'b0;
        if (wait_q && hit10) begin
          held_q    <= 1'b1;
          held_hi_q <= hi_q;
        end
      end
    end
  end

  // R10: a STOP always leaves the hold cleared
  assert_stop_clears_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !held_q);
  // R7: the hold only rises after a pending 10-bit header
  assert_hold_from_header_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_q) |-> $past(wait_q));
  // R8: a read re-match needs the hold
  assert_read_needs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.take && first && ten_en && !gcall) |-> held_q);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int AW = AM_AW,
  parameter int NW = AM_NW,
  parameter int DW = AM_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_first,
  input  logic          bus_stop,
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_second,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_ten_en,
  input  logic          cfg_gc_en,
  output logic          match_pulse,
  output logic          rd_dir,
  output logic          gen_call
);
  logic          byte_ev, hit7, hit10;
  logic [AW-1:0] cand7, cand10;
  am_event_t     ev;
  logic          match_q, dir_q, gc_q;

  assign in_ready = 1'b1;
  assign byte_ev  = in_valid && !bus_stop;

  am_cmp #(.AW(AW), .NW(NW), .WIDE(1'b0)) u_cmp7 (
    .mode(cfg_mode), .cand(cand7), .own(cfg_addr), .second(cfg_second), .hit(hit7)
  );
  am_cmp #(.AW(AW), .NW(NW), .WIDE(1'b1)) u_cmp10 (
    .mode(cfg_mode), .cand(cand10), .own(cfg_addr), .second(cfg_second), .hit(hit10)
  );

  am_phase #(.AW(AW), .DW(DW)) u_phase (
    .clk(clk), .rst_n(rst_n), .byte_ev(byte_ev), .stop(bus_stop),
    .first(in_first), .data(in_data), .ten_en(cfg_ten_en), .gc_en(cfg_gc_en),
    .hit7(hit7), .hit10(hit10), .cand7(cand7), .cand10(cand10), .ev(ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      dir_q   <= 1'b0;
      gc_q    <= 1'b0;
    end else begin
      match_q <= ev.take;
      if (ev.take) begin
        dir_q <= ev.dir;
        gc_q  <= ev.gc;
      end
    end
  end

  assign match_pulse = match_q;
  assign rd_dir      = dir_q;
  assign gen_call    = gc_q;

  // R2: a pulse is always one clock after an accepted byte
  assert_pulse_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> $past(in_valid && !bus_stop));
  // R9: latched outputs move only together with a pulse
  assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !match_q |-> ($stable(dir_q) && $stable(gc_q)));
  // R6: a general call is always a write
  assert_gc_is_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gc_q |-> !dir_q);
  // R10: a byte on a STOP cycle yields no pulse
  assert_stop_drops_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !match_q);
  // R11: never back-pressure
  assert_ready_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

// File: tb/sim_i2c_addr_match.sv
`timescale 1ns/1ps
module sim_i2c_addr_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, bus_stop = 1'b0;
  logic [7:0] in_data = '0;
  logic [9:0] cfg_addr = '0, cfg_second = '0;
  logic [1:0] cfg_mode = '0;
  logic cfg_ten_en = 1'b0, cfg_gc_en = 1'b0;
  logic in_ready, match_pulse, rd_dir, gen_call;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference state
  bit m_wait, m_held, e_dir, e_gc;
  bit [1:0] m_hi, m_hhi;

  always #2 clk = ~clk;

  i2c_addr_match u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .bus_stop(bus_stop),
    .cfg_addr(cfg_addr), .cfg_second(cfg_second), .cfg_mode(cfg_mode),
    .cfg_ten_en(cfg_ten_en), .cfg_gc_en(cfg_gc_en),
    .match_pulse(match_pulse), .rd_dir(rd_dir), .gen_call(gen_call)
  );

  function automatic bit ref_hit(input logic [9:0] a, input bit wide);
    int lim = wide ? 1024 : 128;
    int av = int'(a) % lim;
    int pv = int'(cfg_addr) % lim;
    int sv = int'(cfg_second) % lim;
    if (cfg_mode == 2'd1) return (av == pv) || (av == sv);
    if (cfg_mode == 2'd2) return (sv <= av) && (av <= pv);
    for (int b = 0; b < 10; b++)
      if (b < (wide ? 10 : 7) && !cfg_second[b] && (a[b] != cfg_addr[b])) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // drive one cycle at negedge, predict, check at following negedge
  task automatic step(input bit v, input logic [7:0] d, input bit f, input bit s,
                      input string tag);
    bit em = 1'b0, ed = 1'b0, eg = 1'b0;
    in_valid = v; in_data = d; in_first = f; bus_stop = s;
    if (s) begin
      m_wait = 1'b0; m_held = 1'b0;
    end else if (v) begin
      if (f) begin
        if (cfg_gc_en && d == 8'h00) begin em = 1; eg = 1; end
        else if (!cfg_ten_en) begin em = (d != 0) && ref_hit({3'b0, d[7:1]}, 0); ed = d[0]; end
        else if (d[7:3] == 5'b11110 && d[0]) begin em = m_held && (m_hhi == d[2:1]); ed = 1; end
        if (cfg_ten_en && d[7:3] == 5'b11110 && !d[0]) begin
          m_wait = 1; m_hi = d[2:1]; m_held = 0;
        end else m_wait = 0;
      end else begin
        if (m_wait && ref_hit({m_hi, d}, 1)) begin
          em = 1; m_held = 1; m_hhi = m_hi;
        end
        m_wait = 0;
      end
    end
    if (em) begin e_dir = ed; e_gc = eg; end
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; bus_stop = 1'b0;
    chk(tag, "match_pulse", match_pulse, em);
    chk(tag, "rd_dir", rd_dir, e_dir);
    chk(tag, "gen_call", gen_call, e_gc);
  endtask

  task automatic idle(input string tag);
    step(0, 8'h00, 0, 0, tag);
    chk(tag, "pulse width", match_pulse, 0);
  endtask

  initial begin : wd
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    int unused_seed;
    unused_seed = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    chk("R1", "match_pulse", match_pulse, 0);
    chk("R1", "rd_dir", rd_dir, 0);
    chk("R1", "gen_call", gen_call, 0);
    chk("R11", "in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: no hold after reset, so a 10-bit read header is refused
    cfg_ten_en = 1; cfg_addr = 10'h2a5; cfg_mode = 2'd1; cfg_second = 10'h000;
    step(1, {5'b11110, 2'b10, 1'b1}, 1, 0, "R1");
    cfg_ten_en = 0;

    // R2: 7-bit match, read then write, one-clock pulse
    cfg_addr = 10'h05a; cfg_mode = 2'd0; cfg_second = '0;
    step(1, {7'h5a, 1'b1}, 1, 0, "R2");
    idle("R2");
    step(1, {7'h5a, 1'b0}, 1, 0, "R2");
    // upper config bits ignored in 7-bit mode
    cfg_addr = 10'h35a;
    step(1, {7'h5a, 1'b1}, 1, 0, "R2");
    // R9: a miss leaves dir at 1
    step(1, {7'h5b, 1'b0}, 1, 0, "R9");
    // R3: mask bit 0 don't-care
    cfg_second = 10'h001;
    step(1, {7'h5b, 1'b0}, 1, 0, "R3");
    step(1, {7'h59, 1'b0}, 1, 0, "R3");
    // R4: dual
    cfg_mode = 2'd1; cfg_second = 10'h011;
    step(1, {7'h11, 1'b1}, 1, 0, "R4");
    step(1, {7'h12, 1'b0}, 1, 0, "R4");
    // R5: range bounds
    cfg_mode = 2'd2; cfg_addr = 10'h040; cfg_second = 10'h020;
    step(1, {7'h20, 1'b0}, 1, 0, "R5");
    step(1, {7'h40, 1'b1}, 1, 0, "R5");
    step(1, {7'h1f, 1'b0}, 1, 0, "R5");
    step(1, {7'h41, 1'b0}, 1, 0, "R5");
    // R6 / R12: general call
    cfg_gc_en = 0; cfg_mode = 2'd0; cfg_addr = 10'h000; cfg_second = 10'h000;
    step(1, 8'h00, 1, 0, "R6");
    cfg_gc_en = 1;
    step(1, 8'h00, 1, 0, "R6");
    cfg_addr = 10'h033;
    step(1, {7'h33, 1'b1}, 1, 0, "R12");
    // R11: data byte ignored
    step(1, {7'h33, 1'b1}, 0, 0, "R11");
    // R7 / R8: 10-bit write then read
    cfg_ten_en = 1; cfg_addr = 10'h2c7; cfg_mode = 2'd0; cfg_second = '0;
    step(1, {5'b11110, 2'b10, 1'b0}, 1, 0, "R7");
    step(1, 8'hc7, 0, 0, "R7");
    step(1, {5'b11110, 2'b10, 1'b1}, 1, 0, "R8");
    step(1, {5'b11110, 2'b01, 1'b1}, 1, 0, "R8");
    // R10: stop on a strobe cycle
    step(1, {5'b11110, 2'b10, 1'b1}, 1, 1, "R10");
    step(1, {5'b11110, 2'b10, 1'b1}, 1, 0, "R10");
    step(1, {5'b11110, 2'b10, 1'b0}, 1, 0, "R7");
    step(1, 8'hc6, 0, 0, "R7");
    step(1, {5'b11110, 2'b10, 1'b0}, 1, 0, "R10");
    step(1, 8'hc7, 0, 1, "R10");
    step(1, {5'b11110, 2'b10, 1'b1}, 1, 0, "R10");

    // constrained random
    for (int n = 0; n < 6000; n++) begin
      if (n % 16 == 0) begin
        cfg_mode = 2'($urandom_range(0, 3));
        cfg_ten_en = 1'($urandom_range(0, 1));
        cfg_gc_en = 1'($urandom_range(0, 1));
        cfg_addr = 10'($urandom);
        cfg_second = (cfg_mode == 2'd0) ? 10'($urandom & $urandom) : 10'($urandom);
        if (cfg_mode == 2'd2 && $urandom_range(0, 1) == 1) cfg_second = cfg_addr - 10'($urandom_range(0, 5));
      end
      case ($urandom_range(0, 5))
        0: d = 8'($urandom);
        1: d = {cfg_addr[6:0], 1'($urandom)};
        2: d = {cfg_second[6:0], 1'($urandom)};
        3: d = {5'b11110, cfg_addr[9:8], 1'($urandom)};
        4: d = cfg_addr[7:0] ^ 8'($urandom_range(0, 1));
        default: d = 8'h00;
      endcase
      step($urandom_range(0, 9) != 0, d, $urandom_range(0, 1) == 1,
           $urandom_range(0, 9) == 0, "R9");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule